// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Runtime Frame Format

This block is a full-duplex serial transceiver for clocked (synchronous) links in which it is the clock master. A word offered on the parallel transmit side is wrapped into a frame and shifted out on `txd`. The block drives the serial clock `sclk` for that frame by dividing the system clock. While that clock runs, the receiver watches `rxd` for a low start bit and collects a frame of the same format. It returns the word with a parity error flag and a framing error flag.

The format is set at runtime:
- five to nine data bits;
- no parity, even parity or odd parity;
- one or two stop bits;
- a clock polarity bit, which decides which `sclk` edge launches transmit bits and which edge samples receive bits.

All combinations are legal, so 30 frame formats are available. A new setting takes effect only when a word is accepted, so a frame never changes format partway through. When another word is waiting at the end of a frame, the next frame follows with no idle time between them.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Each frame begins with a single low start bit, followed by the data bits least significant first. The data bit count is `cfg_nbits`+5 for codes 0 to 4, and 9 for codes 5 to 7.
- R2: `cfg_par` selects the parity mode: 2'b00 and 2'b01 send no parity bit, 2'b10 sends even parity and 2'b11 sends odd parity. When enabled, the parity bit comes directly after the last data bit. With it, the total number of ones over the data and parity bits is even (even mode) or odd (odd mode).
- R3: The frame closes with one high stop bit, or two when `cfg_two_stop` is 1. `txd` is high out of reset and whenever no frame is running.
- R4: Each half period of `sclk` lasts `cfg_half` system cycles, and a value of 0 counts as 1. While no frame runs, `sclk` rests at the level of `cfg_pol`.
- R5: `txd` changes only on the `sclk` edge that leaves the rest level (rising when `cfg_pol` is 0, falling when it is 1). `rxd` is sampled on the edge that returns to the rest level.
- R6: The receiver starts a frame when it samples `rxd` low while idle. After it samples the first stop bit, it pulses `rx_valid` for one cycle with the word on `rx_data`, and the bits above the data count are zero.
- R7: `rx_perr` pulses with `rx_valid` when the received parity bit does not match the mode. `rx_ferr` pulses with `rx_valid` when the first stop bit is sampled low.
- R8: `tx_ready` is high while idle and on the cycle of the last sample edge of a frame. A word accepted on that cycle starts its frame half a period later, with `sclk` running on without a pause. `tx_ready` is low at all other times during a frame.
- R9: Format, divider and polarity are captured when a word is accepted. Changes to the inputs during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | Half period of `sclk` in system cycles |
| cfg_nbits | input | 3 | Data bit count code |
| cfg_par | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_pol | input | 1 | Clock polarity and rest level |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted when high with `tx_valid` |
| sclk | output | 1 | Serial clock |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_perr | output | 1 | Parity error, with `rx_valid` |
| rx_ferr | output | 1 | Framing error, with `rx_valid` |

## Verification
The bench uses the default divider width `DIV_W` = 8 and drives half periods from 0 to 4. Half periods of 0 and 1 put the launch and sample edges on consecutive system cycles, which is the tightest timing for the receiver and for back-to-back hand-off. The bench loops `txd` back to `rxd` through a flip it controls, so a chosen data, parity or first stop bit can be corrupted. This exercises both error flags across all eight count codes and all four parity codes, in both polarities.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    localparam int DMAX  = 9;                  // widest data field
    localparam int FR_W  = 1 + DMAX + 1 + 2;   // longest frame
    localparam int IDX_W = $clog2(FR_W + 1);

    typedef struct packed {
        logic [2:0] nbc;   // data count code
        logic [1:0] par;   // [1] enable, [0] odd
        logic       st2;   // two stop bits
        logic       pol;   // clock polarity
    } cfg_t;

    function automatic logic [IDX_W-1:0] nbits_of(input logic [2:0] code);
        return (code > 3'd4) ? IDX_W'(DMAX) : IDX_W'(code) + IDX_W'(5);
    endfunction
endpackage

// File: rtl/ssx_frame_build.sv
module ssx_frame_build
    import ssx_pkg::*;
(
    input  logic [DMAX-1:0]  data,
    input  cfg_t             cfg,
    output logic [FR_W-1:0]  frame,
    output logic [IDX_W-1:0] len
);
    logic [IDX_W-1:0] nb;
    logic             pbit;

    always_comb begin
        nb    = nbits_of(cfg.nbc);
        pbit  = cfg.par[0];
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DMAX; i++) begin
            if (IDX_W'(i) < nb) begin
                frame[i + 1] = data[i];
                pbit         = pbit ^ data[i];
            end
        end
        if (cfg.par[1]) frame[nb + IDX_W'(1)] = pbit;
        len = IDX_W'(1) + nb + IDX_W'(cfg.par[1]) + (cfg.st2 ? IDX_W'(2) : IDX_W'(1));
    end
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx
    import ssx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_in,
    input  cfg_t             cfg_in,
    input  logic [FR_W-1:0]  frame_in,
    input  logic [IDX_W-1:0] len_in,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             busy,
    output logic             sclk,
    output logic             txd,
    output logic             smp,
    output logic [2:0]       act_nbc,
    output logic [1:0]       act_par
);
    typedef struct packed {
        logic             busy;
        logic             ph;     // 1: clock at active level, sample pending
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] half;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] len;
        logic [FR_W-1:0]  fr;
        cfg_t             cfg;
        logic             sclk;
        logic             txd;
    } st_t;

    st_t q, d;
    logic tick, launch, sample, last;
    logic [DIV_W-1:0] half_eff;

    always_comb begin
        half_eff = (half_in == '0) ? DIV_W'(1) : half_in;
        tick     = q.busy && (q.cnt == '0);
        launch   = tick && !q.ph;
        sample   = tick && q.ph;
        last     = sample && (q.idx == q.len - IDX_W'(1));
        tx_ready = !q.busy || last;

        d = q;
        if (!q.busy) begin
            d.sclk = cfg_in.pol;
        end else if (launch) begin
            d.sclk = ~q.cfg.pol;
            d.txd  = q.fr[q.idx];
            d.ph   = 1'b1;
            d.cnt  = q.half - DIV_W'(1);
        end else if (sample) begin
            d.sclk = q.cfg.pol;
            d.ph   = 1'b0;
            d.cnt  = q.half - DIV_W'(1);
            d.idx  = q.idx + IDX_W'(1);
            if (last) d.busy = 1'b0;
        end else begin
            d.cnt = q.cnt - DIV_W'(1);
        end

        if (tx_valid && tx_ready) begin
            d.busy = 1'b1;
            d.ph   = 1'b0;
            d.cnt  = half_eff - DIV_W'(1);
            d.half = half_eff;
            d.idx  = '0;
            d.len  = len_in;
            d.fr   = frame_in;
            d.cfg  = cfg_in;
            d.sclk = cfg_in.pol;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign sclk    = q.sclk;
    assign txd     = q.txd;
    assign smp     = sample;
    assign act_nbc = q.cfg.nbc;
    assign act_par = q.cfg.par;
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx
    import ssx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp,
    input  logic            rxd,
    input  logic [2:0]      nbc,
    input  logic [1:0]      par,
    output logic [DMAX-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_perr,
    output logic            rx_ferr
);
    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
        logic [DMAX-1:0]  sh;
        logic             acc;
        logic             perr_p;
        logic [DMAX-1:0]  o_data;
        logic             o_vld;
        logic             o_perr;
        logic             o_ferr;
    } st_t;

    st_t q, d;
    logic [IDX_W-1:0] nb;

    always_comb begin
        nb = nbits_of(nbc);
        d  = q;
        d.o_vld  = 1'b0;
        d.o_perr = 1'b0;
        d.o_ferr = 1'b0;
        if (smp) begin
            if (!q.act) begin
                if (!rxd) begin
                    d.act    = 1'b1;
                    d.idx    = '0;
                    d.sh     = '0;
                    d.acc    = 1'b0;
                    d.perr_p = 1'b0;
                end
            end else if (q.idx < nb) begin
                for (int i = 0; i < DMAX; i++)
                    if (q.idx == IDX_W'(i)) d.sh[i] = rxd;
                d.acc = q.acc ^ rxd;
                d.idx = q.idx + IDX_W'(1);
            end else if (par[1] && (q.idx == nb)) begin
                d.perr_p = (q.acc ^ rxd) != par[0];
                d.idx    = q.idx + IDX_W'(1);
            end else begin
                d.act    = 1'b0;
                d.o_vld  = 1'b1;
                d.o_data = q.sh;
                d.o_perr = q.perr_p;
                d.o_ferr = !rxd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data  = q.o_data;
    assign rx_valid = q.o_vld;
    assign rx_perr  = q.o_perr;
    assign rx_ferr  = q.o_ferr;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic [2:0]       cfg_nbits,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_two_stop,
    input  logic             cfg_pol,
    input  logic [8:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             sclk,
    output logic             txd,
    input  logic             rxd,
    output logic [8:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_perr,
    output logic             rx_ferr
);
    cfg_t             cfg;
    logic [FR_W-1:0]  frame;
    logic [IDX_W-1:0] len;
    logic             tx_busy, smp_evt;
    logic [2:0]       act_nbc;
    logic [1:0]       act_par;

    assign cfg = '{nbc: cfg_nbits, par: cfg_par, st2: cfg_two_stop, pol: cfg_pol};

    ssx_frame_build u_build (
        .data (tx_data),
        .cfg  (cfg),
        .frame(frame),
        .len  (len)
    );

    ssx_tx #(.DIV_W(DIV_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_in (cfg_half),
        .cfg_in  (cfg),
        .frame_in(frame),
        .len_in  (len),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .busy    (tx_busy),
        .sclk    (sclk),
        .txd     (txd),
        .smp     (smp_evt),
        .act_nbc (act_nbc),
        .act_par (act_par)
    );

    ssx_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp_evt),
        .rxd     (rxd),
        .nbc     (act_nbc),
        .par     (act_par),
        .rx_data (rx_data),
        .rx_valid(rx_valid),
        .rx_perr (rx_perr),
        .rx_ferr (rx_ferr)
    );
endmodule

// File: rtl/ssx_chk.sv
module ssx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_pol,
    input logic tx_busy,
    input logic tx_ready,
    input logic sclk,
    input logic txd,
    input logic rx_valid,
    input logic rx_perr,
    input logic rx_ferr
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !tx_busy && !$past(tx_busy)) |-> (txd && (sclk == $past(cfg_pol)))); // R4

    AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> !$stable(sclk)); // R5

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_FLAG_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_perr || rx_ferr) |-> rx_valid); // R7

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_ready); // R8
endmodule

bind sync_serial_xcvr ssx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_pol (cfg_pol),
    .tx_busy (tx_busy),
    .tx_ready(tx_ready),
    .sclk    (sclk),
    .txd     (txd),
    .rx_valid(rx_valid),
    .rx_perr (rx_perr),
    .rx_ferr (rx_ferr)
);

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [DW-1:0] cfg_half = 1;
    logic [2:0] cfg_nbits = 3;
    logic [1:0] cfg_par = 0;
    logic cfg_two_stop = 0, cfg_pol = 0;
    logic [8:0] tx_data = 0;
    logic tx_valid = 0;
    logic tx_ready, sclk, txd, rxd, rx_valid, rx_perr, rx_ferr;
    logic [8:0] rx_data;
    logic flip = 1'b0;

    assign rxd = txd ^ flip;

    sync_serial_xcvr #(.DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_nbits(cfg_nbits),
        .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .cfg_pol(cfg_pol),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sclk(sclk), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    int total = 0, bad = 0;

    // line monitor
    bit mon_en = 0;
    logic mon_pol = 0;
    int mon_half = 1;
    int nl, ns, ntr, gap, gapbad, edgebad, corrupt_at = -1;
    logic [31:0] seen;
    logic sclk_prev, txd_prev;
    int nrx = 0;
    logic [8:0] rxw [0:3];
    logic rxp [0:3];
    logic rxf [0:3];

    always @(negedge clk) begin
        if (mon_en) begin
            gap++;
            if (txd !== txd_prev && !(sclk !== sclk_prev && sclk != mon_pol)) edgebad++;
            if (sclk !== sclk_prev) begin
                if (ntr > 0 && gap != mon_half) gapbad++;
                ntr++;
                gap = 0;
                if (sclk != mon_pol) begin
                    flip = (nl == corrupt_at);
                    nl++;
                end else begin
                    flip = 1'b0;
                    if (ns < 32) seen[ns] = txd;
                    ns++;
                end
            end
        end
        sclk_prev = sclk;
        txd_prev  = txd;
        if (rx_valid && nrx < 4) begin
            rxw[nrx] = rx_data;
            rxp[nrx] = rx_perr;
            rxf[nrx] = rx_ferr;
            nrx++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input logic [2:0] c);
        return (c > 4) ? 9 : int'(c) + 5;
    endfunction

    function automatic void mk_frame(input logic [8:0] d, input logic [2:0] nbc, input logic [1:0] par,
                                     input logic st2, output logic [31:0] f, output int len);
        int nb = nbits(nbc);
        logic ones = 1'b0;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            f[1 + i] = d[i];
            ones ^= d[i];
        end
        if (par[1]) f[1 + nb] = ones ^ par[0];
        len = 1 + nb + int'(par[1]) + (st2 ? 2 : 1);
    endfunction

    // expected receive result from a (possibly corrupted) bit vector
    task automatic exp_rx(input logic [31:0] cb, input logic [2:0] nbc, input logic [1:0] par,
                          output logic [8:0] ed, output logic ep, output logic ef);
        int nb = nbits(nbc);
        int pe = int'(par[1]);
        logic ones = 1'b0;
        ed = '0;
        for (int i = 0; i < nb; i++) begin
            ed[i] = cb[1 + i];
            ones ^= cb[1 + i];
        end
        ep = par[1] && ((ones ^ cb[1 + nb]) != par[0]);
        ef = !cb[1 + nb + pe];
    endtask

    task automatic arm(input logic pol, input int half, input int corrupt);
        nl = 0; ns = 0; ntr = 0; gap = 0; gapbad = 0; edgebad = 0;
        corrupt_at = corrupt; mon_pol = pol; mon_half = (half == 0) ? 1 : half;
        nrx = 0; flip = 1'b0; seen = '1;
        sclk_prev = sclk; txd_prev = txd;
        mon_en = 1;
    endtask

    task automatic set_cfg(input logic [2:0] nbc, input logic [1:0] par, input logic st2,
                           input logic pol, input int half);
        cfg_nbits = nbc; cfg_par = par; cfg_two_stop = st2; cfg_pol = pol; cfg_half = DW'(half);
    endtask

    task automatic run_frame(input logic [8:0] d, input logic [2:0] nbc, input logic [1:0] par,
                             input logic st2, input logic pol, input int half,
                             input int corrupt, input bit midchg);
        logic [31:0] f, cb;
        int len, nb, pe, t;
        logic [8:0] ed;
        logic ep, ef;
        bit ok;
        mk_frame(d, nbc, par, st2, f, len);
        nb = nbits(nbc);
        pe = int'(par[1]);
        @(negedge clk);
        mon_en = 0;
        set_cfg(nbc, par, st2, pol, half);
        repeat (3) @(negedge clk);
        chk(sclk == pol && txd == 1'b1, "R4", "rest sclk/txd", {sclk, txd}, {pol, 1'b1});
        arm(pol, half, corrupt);
        tx_data = d;
        tx_valid = 1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 0;
        tx_data = 9'($urandom);
        chk(!tx_ready, "R8", "ready low mid-frame", tx_ready, 0);
        if (midchg) begin
            repeat (2) @(negedge clk);
            cfg_nbits = ~nbc; cfg_par = ~par; cfg_two_stop = ~st2; cfg_half = DW'(half + 3);
        end
        t = 0;
        while (ns < len && t < 4000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        mon_en = 0;

        chk(ns == len, "R3", "frame bit count", ns, len);
        if (midchg) chk(ns == len, "R9", "length kept after mid-frame change", ns, len);
        chk(seen[0] == 1'b0, "R1", "start bit", seen[0], 0);
        ok = 1;
        for (int k = 1; k <= nb; k++) if (seen[k] !== f[k]) ok = 0;
        chk(ok, "R1", "data bits lsb first", seen[9:1], f[9:1]);
        if (pe == 1) chk(seen[1 + nb] === f[1 + nb], "R2", "parity bit", seen[1 + nb], f[1 + nb]);
        ok = 1;
        for (int k = 1 + nb + pe; k < len; k++) if (seen[k] !== 1'b1) ok = 0;
        chk(ok, "R3", "stop bits high", seen[12:0], f[12:0]);
        chk(gapbad == 0, "R4", "half period length", gapbad, 0);
        chk(edgebad == 0, "R5", "txd only on leaving edge", edgebad, 0);

        cb = f;
        if (corrupt >= 0) cb[corrupt] = ~cb[corrupt];
        exp_rx(cb, nbc, par, ed, ep, ef);
        chk(nrx == 1, "R6", "one rx strobe", nrx, 1);
        chk(rxw[0] === ed, "R6", "rx word", rxw[0], ed);
        chk(rxp[0] === ep, "R7", "parity error flag", rxp[0], ep);
        chk(rxf[0] === ef, "R7", "framing error flag", rxf[0], ef);
    endtask

    // two words handed over back to back; second format set after first is accepted
    task automatic run_b2b(input logic [8:0] d1, input logic [8:0] d2, input logic [2:0] n1,
                           input logic [1:0] p1, input logic s1, input logic [2:0] n2,
                           input logic [1:0] p2, input logic s2, input logic pol, input int half);
        logic [31:0] f1, f2;
        int l1, l2, t;
        bit ok;
        mk_frame(d1, n1, p1, s1, f1, l1);
        mk_frame(d2, n2, p2, s2, f2, l2);
        @(negedge clk);
        mon_en = 0;
        set_cfg(n1, p1, s1, pol, half);
        repeat (3) @(negedge clk);
        arm(pol, half, -1);
        tx_data = d1;
        tx_valid = 1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_data = d2;
        cfg_nbits = n2; cfg_par = p2; cfg_two_stop = s2;
        chk(!tx_ready, "R8", "ready low during first frame", tx_ready, 0);
        t = 0;
        while (!tx_ready && t < 4000) begin @(negedge clk); t++; end
        chk(ns == l1 - 1, "R8", "ready at last sample edge", ns, l1 - 1);
        @(negedge clk);
        tx_valid = 0;
        t = 0;
        while (ns < l1 + l2 && t < 4000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        mon_en = 0;
        chk(ns == l1 + l2, "R8", "total bits two frames", ns, l1 + l2);
        chk(gapbad == 0, "R8", "sclk continuous across frames", gapbad, 0);
        ok = 1;
        for (int k = 0; k < l1; k++) if (seen[k] !== f1[k]) ok = 0;
        chk(ok, "R9", "first frame keeps its format", seen[12:0], f1[12:0]);
        ok = 1;
        for (int k = 0; k < l2; k++) if (seen[l1 + k] !== f2[k]) ok = 0;
        chk(ok, "R9", "second frame uses new format", seen[l1 +: 13], f2[12:0]);
        chk(nrx == 2, "R6", "two rx strobes", nrx, 2);
        chk(rxw[0] === (d1 & 9'((1 << nbits(n1)) - 1)), "R6", "rx word 1", rxw[0], d1);
        chk(rxw[1] === (d2 & 9'((1 << nbits(n2)) - 1)), "R6", "rx word 2", rxw[1], d2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(txd == 1'b1, "R3", "txd high in reset", txd, 1);
        chk(rx_valid == 1'b0, "R6", "no rx strobe in reset", rx_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R8", "ready after reset", tx_ready, 1);

        // directed: every count code, parity modes, polarities
        for (int c = 0; c < 8; c++)
            run_frame(9'h1A5, 3'(c), 2'(c % 4), c[0], c[1], 1 + c % 3, -1, 0);
        run_frame(9'h000, 3'd3, 2'b10, 0, 0, 2, -1, 0);   // even, no ones
        run_frame(9'h1FF, 3'd4, 2'b11, 1, 1, 1, -1, 0);   // odd, nine ones
        run_frame(9'h0FF, 3'd3, 2'b10, 0, 1, 0, -1, 0);   // half of 0 acts as 1
        run_frame(9'h055, 3'd3, 2'b10, 0, 0, 2, 3, 0);    // data bit corrupted, R7 parity
        run_frame(9'h055, 3'd3, 2'b11, 1, 1, 1, 9, 0);    // parity bit corrupted
        run_frame(9'h0AA, 3'd0, 2'b00, 0, 0, 1, 6, 0);    // first stop corrupted, R7 framing
        run_frame(9'h13C, 3'd4, 2'b11, 1, 0, 2, 11, 0);   // first stop after parity
        run_frame(9'h0C3, 3'd2, 2'b10, 1, 1, 3, -1, 1);   // R9 mid-frame change
        run_b2b(9'h0F0, 9'h1E1, 3'd3, 2'b10, 0, 3'd4, 2'b11, 1, 0, 1);
        run_b2b(9'h011, 9'h022, 3'd0, 2'b00, 1, 3'd1, 2'b10, 0, 1, 3);

        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [2:0] nbc = 3'($urandom % 8);
            logic [1:0] par = 2'($urandom % 4);
            int nb = nbits(nbc);
            int pe = int'(par[1]);
            int corrupt = -1;
            if ($urandom % 3 == 0) corrupt = 1 + int'($urandom % (nb + pe + 1));
            run_frame(9'($urandom), nbc, par, 1'($urandom), 1'($urandom),
                      int'($urandom % 5), corrupt, ($urandom % 6) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule